// File: doc/BRIEF.md
# Descriptor-Ring Audio Playback DMA Channel

This block is one playback channel of an audio bus-master engine. Software builds a circular table of up to 32 buffer descriptors in memory. Each descriptor is 8 bytes long: the first word is a dword-aligned pointer to the sample buffer, and the second word is a control word. In the control word, bit 31 asks for a completion flag, bit 30 selects the underrun policy, and bits 15:0 give the length in 32-bit left/right sample words. Software writes the table base and a last-valid index, then sets run. The channel fetches each descriptor in turn, reads the sample words one at a time, and hands them to a downstream sample sink over a valid/ready pair.

The channel moves through the table modulo 32. It stops after the buffer whose index equals the last-valid index. If that buffer carries the underrun-policy bit, the channel keeps offering silent samples while it is stopped. Software extends playback by moving the last-valid index forward. Status bits report halted, at-last, last-buffer-done and buffer-complete, and an interrupt line combines the enabled status sources. A register-reset command clears the channel's state but keeps the interrupt-enable bits.

Top module: `adma_play_chan`

## Requirements
- R1: After reset, status reads 0x3 (bit 0 halted, bit 1 at-last), the index register reads 0x00010000, position, base and control read 0, and irq, mem_req and smp_valid are low.
- R2: For index i, the descriptor pointer is read at base+8*i and the control word at base+8*i+4. Sample words are then read from consecutive dword addresses starting at the pointer and are delivered in order, one per handshake, even under backpressure on both sides. A descriptor whose length is 0 delivers nothing and is passed over.
- R3: The position register (offset 0x08, bits 15:0) is loaded with the descriptor length and drops by one for each sample accepted, reaching 0 at the end of the buffer.
- R4: The index register (offset 0x04) holds the last-valid index in bits 4:0, the current index in bits 12:8 and the prefetched index in bits 20:16. The current index steps by one after each buffer, modulo 32, and the prefetched index is always current+1 modulo 32.
- R5: After completing the buffer whose index equals the last-valid index, status bit 2 and status bit 0 are set. From then on the channel issues no memory reads and delivers no further buffer data.
- R6: Status bit 1 reads 1 exactly when the current index equals the last-valid index.
- R7: Status bit 3 sets when a buffer whose control bit 31 is 1 completes. Writing 1 to status bit 2 or bit 3 clears that bit, and writing 0 leaves it unchanged.
- R8: irq is high when (status bit 2 AND control bit 2) OR (status bit 3 AND control bit 4).
- R9: If the stopping buffer has control bit 30 set, smp_valid stays high with smp_data 0 while the channel is stopped. Otherwise smp_valid stays low.
- R10: While stopped, writing a new last-valid index resumes the channel at current index + 1.
- R11: Clearing control bit 0 sets status bit 0, stops memory reads and sample delivery, and freezes the position. Setting the bit again resumes from the same point with no sample lost or repeated.
- R12: Writing control bit 1 while control bit 0 is 0 clears base, indices, position, status bits 2 and 3, and control bits 1:0, and keeps control bits 4:2 at their previous values. If run is 1, bit 1 is ignored. Control bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address: 0x00 base, 0x04 index, 0x08 position, 0x0C status, 0x10 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ready | input | 1 | Memory accepts the request; mem_rdata is valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| smp_valid | output | 1 | Sample word offered |
| smp_data | output | 32 | Stereo sample word |
| smp_ready | input | 1 | Sink accepts the sample |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that memory returns data in the same cycle it raises mem_ready. They also assume that software sets register reset only while paused and never rewrites the table entry currently being fetched. The stall property assumes that run drops only through a register write. The stimulus writes each descriptor before the channel can reach it, and resets the channel only after a control write that clears run. Ready patterns come from a shift register so that stalls hit every fetch and output phase.

// File: rtl/adma_pkg.sv
package adma_pkg;

    typedef enum logic [2:0] {
        ST_DPTR = 3'd0,
        ST_DCTL = 3'd1,
        ST_DATA = 3'd2,
        ST_OUT  = 3'd3,
        ST_DONE = 3'd4,
        ST_END  = 3'd5
    } adma_state_e;

    localparam int OFS_BASE = 'h00;
    localparam int OFS_IDX  = 'h04;
    localparam int OFS_POS  = 'h08;
    localparam int OFS_STS  = 'h0C;
    localparam int OFS_CTL  = 'h10;

    localparam int CTL_RUN  = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_LVBE = 2;
    localparam int CTL_IOCE = 4;

    localparam int STS_LVB  = 2;
    localparam int STS_CMP  = 3;

endpackage

// File: rtl/adma_rdmux.sv
module adma_rdmux #(
    parameter int AW    = 32,
    parameter int IDX_W = 5,
    parameter int LEN_W = 16,
    parameter int RA_W  = 5
) (
    input  logic [RA_W-1:0]  addr,
    input  logic [AW-4:0]    base,
    input  logic [IDX_W-1:0] lvi,
    input  logic [IDX_W-1:0] civ,
    input  logic [IDX_W-1:0] pfi,
    input  logic [LEN_W-1:0] pos,
    input  logic [3:0]       sts,
    input  logic [4:0]       ctl,
    output logic [31:0]      rdata
);
    import adma_pkg::*;

    always_comb begin
        case (addr)
            RA_W'(OFS_BASE): rdata = 32'({base, 3'b000});
            RA_W'(OFS_IDX):  rdata = 32'(lvi) | (32'(civ) << 8) | (32'(pfi) << 16);
            RA_W'(OFS_POS):  rdata = 32'(pos);
            RA_W'(OFS_STS):  rdata = 32'(sts);
            RA_W'(OFS_CTL):  rdata = 32'(ctl);
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/adma_play_chan.sv
module adma_play_chan #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IDX_W = 5,
    parameter int LEN_W = 16,
    parameter int RA_W  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata,
    output logic            smp_valid,
    output logic [DW-1:0]   smp_data,
    input  logic            smp_ready,
    output logic            irq
);
    import adma_pkg::*;

    localparam int DESC_SH = 3;
    localparam int PTR_W   = AW - 2;
    localparam int BASE_W  = AW - DESC_SH;

    typedef struct packed {
        adma_state_e       st;
        logic [BASE_W-1:0] base;
        logic [IDX_W-1:0]  lvi;
        logic [IDX_W-1:0]  civ;
        logic [PTR_W-1:0]  ptr;
        logic [LEN_W-1:0]  pos;
        logic              ioc;
        logic              bup;
        logic              fill;
        logic [DW-1:0]     smp;
        logic              lvb;
        logic              cmp;
        logic [4:0]        ctl;
    } chan_regs_t;

    chan_regs_t r_d, r_q;

    logic             run;
    logic             at_end;
    logic             halted;
    logic             at_last;
    logic [IDX_W-1:0] pf_idx;
    logic [AW-1:0]    desc_addr;

    assign run       = r_q.ctl[CTL_RUN];
    assign at_end    = (r_q.st == ST_END);
    assign halted    = !run || at_end;
    assign at_last   = (r_q.civ == r_q.lvi);
    assign pf_idx    = r_q.civ + IDX_W'(1);
    assign desc_addr = {r_q.base, 3'b000} + AW'({r_q.civ, 3'b000});

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_addr  = desc_addr;
        smp_valid = 1'b0;
        smp_data  = r_q.smp;

        // register writes first, so that a status set below wins over a clear
        if (reg_wr) begin
            case (reg_addr)
                RA_W'(OFS_BASE): r_d.base = reg_wdata[AW-1:DESC_SH];
                RA_W'(OFS_IDX):  r_d.lvi  = reg_wdata[IDX_W-1:0];
                RA_W'(OFS_STS): begin
                    if (reg_wdata[STS_LVB]) r_d.lvb = 1'b0;
                    if (reg_wdata[STS_CMP]) r_d.cmp = 1'b0;
                end
                RA_W'(OFS_CTL): begin
                    if (reg_wdata[CTL_RST] && !run) begin
                        r_d.base = '0;
                        r_d.lvi  = '0;
                        r_d.civ  = '0;
                        r_d.pos  = '0;
                        r_d.lvb  = 1'b0;
                        r_d.cmp  = 1'b0;
                        r_d.fill = 1'b0;
                        r_d.st   = ST_DPTR;
                        r_d.ctl  = {r_q.ctl[4:2], 2'b00};
                    end else begin
                        r_d.ctl = {reg_wdata[4:2], 1'b0, reg_wdata[CTL_RUN]};
                    end
                end
                default: ;
            endcase
        end

        if (run) begin
            case (r_q.st)
                ST_DPTR: begin
                    mem_req = 1'b1;
                    if (mem_ready) begin
                        r_d.ptr = mem_rdata[AW-1:2];
                        r_d.st  = ST_DCTL;
                    end
                end
                ST_DCTL: begin
                    mem_req  = 1'b1;
                    mem_addr = desc_addr + AW'(4);
                    if (mem_ready) begin
                        r_d.ioc = mem_rdata[DW-1];
                        r_d.bup = mem_rdata[DW-2];
                        r_d.pos = mem_rdata[LEN_W-1:0];
                        r_d.st  = (mem_rdata[LEN_W-1:0] == '0) ? ST_DONE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    mem_req  = 1'b1;
                    mem_addr = {r_q.ptr, 2'b00};
                    if (mem_ready) begin
                        r_d.smp = mem_rdata;
                        r_d.ptr = r_q.ptr + PTR_W'(1);
                        r_d.st  = ST_OUT;
                    end
                end
                ST_OUT: begin
                    smp_valid = 1'b1;
                    if (smp_ready) begin
                        r_d.pos = r_q.pos - LEN_W'(1);
                        r_d.st  = (r_q.pos == LEN_W'(1)) ? ST_DONE : ST_DATA;
                    end
                end
                ST_DONE: begin
                    if (r_q.ioc) r_d.cmp = 1'b1;
                    if (at_last) begin
                        r_d.lvb  = 1'b1;
                        r_d.fill = r_q.bup;
                        r_d.st   = ST_END;
                    end else begin
                        r_d.civ = pf_idx;
                        r_d.st  = ST_DPTR;
                    end
                end
                ST_END: begin
                    smp_valid = r_q.fill;
                    smp_data  = '0;
                    if (!at_last && (!r_q.fill || smp_ready)) begin
                        r_d.civ  = pf_idx;
                        r_d.fill = 1'b0;
                        r_d.st   = ST_DPTR;
                    end
                end
                default: r_d.st = ST_DPTR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq = (r_q.lvb && r_q.ctl[CTL_LVBE]) || (r_q.cmp && r_q.ctl[CTL_IOCE]);

    adma_rdmux #(
        .AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W), .RA_W(RA_W)
    ) u_rdmux (
        .addr  (reg_addr),
        .base  (r_q.base),
        .lvi   (r_q.lvi),
        .civ   (r_q.civ),
        .pfi   (pf_idx),
        .pos   (r_q.pos),
        .sts   ({r_q.cmp, r_q.lvb, at_last, halted}),
        .ctl   (r_q.ctl),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/adma_play_chan_chk.sv
module adma_play_chan_chk #(
    parameter int DW    = 32,
    parameter int IDX_W = 5,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic [DW-1:0]    smp_data,
    input logic             irq,
    input logic             run,
    input logic             at_end,
    input logic [IDX_W-1:0] civ,
    input logic [LEN_W-1:0] pos,
    input logic             lvb,
    input logic             cmp
);

    p_hold_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (!run || (smp_valid && $stable(smp_data))));

    p_pos_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready && !at_end) |=> (pos == $past(pos) - LEN_W'(1)));

    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(civ) |-> (civ == $past(civ) + IDX_W'(1) || civ == '0));

    p_stop_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |-> !mem_req);

    p_lvb_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvb) |-> at_end);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (lvb || cmp));

    p_pause_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!mem_req && !smp_valid));

endmodule

bind adma_play_chan adma_play_chan_chk #(
    .DW(DW), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .irq       (irq),
    .run       (run),
    .at_end    (at_end),
    .civ       (r_q.civ),
    .pos       (r_q.pos),
    .lvb       (r_q.lvb),
    .cmp       (r_q.cmp)
);

// File: tb/adma_play_chan_test.sv
module adma_play_chan_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_BASE = 5'h00, A_IDX = 5'h04, A_POS = 5'h08,
                           A_STS = 5'h0C, A_CTL = 5'h10;
    localparam int LIST = 'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic        smp_ready = 1'b0;
    logic        irq;

    logic [31:0] mem [256];
    logic [31:0] got [512];
    int ngot = 0, nreq = 0, checks = 0, errors = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    adma_play_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        if (stall) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = lfsr[0] | lfsr[3];
            smp_ready = lfsr[1];
        end else begin
            mem_ready = 1'b1;
            smp_ready = 1'b1;
        end
        if (smp_valid && smp_ready && ngot < 512) begin
            got[ngot] = smp_data;
            ngot++;
        end
        if (mem_req && mem_ready) nreq++;
    end

    function automatic logic [31:0] wexp(int a);
        return 32'hC0DE_0000 | 32'(a >> 2);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_desc(int idx, logic [31:0] ptr, logic [31:0] ctl);
        mem[(LIST >> 2) + idx*2]     = ptr;
        mem[(LIST >> 2) + idx*2 + 1] = ctl;
    endtask

    task automatic wait_lvb();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STS, v);
            if (v[2]) break;
        end
    endtask

    task automatic chan_reset();
        wr(A_CTL, 32'h00);
        wr(A_CTL, 32'h02);
        wr(A_STS, 32'h0C);
        wr(A_BASE, LIST);
        ngot = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 smp_valid", 32'(smp_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(A_STS, v);  chk("R1 R6 status", v, 32'h3);
        rd(A_IDX, v);  chk("R1 index", v, 32'h0001_0000);
        rd(A_POS, v);  chk("R1 position", v, 0);
        rd(A_CTL, v);  chk("R1 control", v, 0);
        rd(A_BASE, v); chk("R1 base", v, 0);
    endtask

    task automatic t_play();
        logic [31:0] v;
        int r0, g0;
        put_desc(0, 32'h200, 32'h8000_0003);
        put_desc(1, 32'h220, 32'h0000_0000);
        put_desc(2, 32'h240, 32'h0000_0002);
        ngot = 0;
        wr(A_BASE, LIST);
        wr(A_IDX, 32'd2);
        wr(A_CTL, 32'h11);
        wait (ngot == 1);
        rd(A_POS, v); chk("R3 position mid buffer", v, 32'd2);
        rd(A_STS, v); chk("R6 status while running", v, 32'h0);
        wait_lvb();
        chk("R2 sample count", 32'(ngot), 32'd5);
        chk("R2 sample 0", got[0], wexp('h200));
        chk("R2 sample 1", got[1], wexp('h204));
        chk("R2 sample 2", got[2], wexp('h208));
        chk("R2 sample 3 after empty buffer", got[3], wexp('h240));
        chk("R2 sample 4", got[4], wexp('h244));
        rd(A_STS, v); chk("R5 R6 R7 status at stop", v, 32'hF);
        rd(A_IDX, v); chk("R4 index at stop", v, 32'h0003_0202);
        rd(A_POS, v); chk("R3 position at end", v, 0);
        chk("R8 irq on complete", 32'(irq), 1);
        r0 = nreq; g0 = ngot;
        repeat (20) @(negedge clk);
        chk("R5 no reads after stop", 32'(nreq), 32'(r0));
        chk("R5 no samples after stop", 32'(ngot), 32'(g0));
        wr(A_STS, 32'h8);
        rd(A_STS, v); chk("R7 clear complete bit", v, 32'h7);
        chk("R8 irq off with last-buffer enable clear", 32'(irq), 0);
        wr(A_STS, 32'h0);
        rd(A_STS, v); chk("R7 write 0 no effect", v, 32'h7);
        wr(A_STS, 32'h4);
        rd(A_STS, v); chk("R7 clear last-done bit", v, 32'h3);
    endtask

    task automatic t_regreset();
        logic [31:0] v;
        wr(A_CTL, 32'h1F);
        rd(A_BASE, v); chk("R12 reset ignored while running", v, LIST);
        rd(A_CTL, v);  chk("R12 control readback", v, 32'h1D);
        wr(A_CTL, 32'h1C);
        rd(A_STS, v);  chk("R11 halted after pause", v & 32'h1, 32'h1);
        wr(A_CTL, 32'h02);
        rd(A_CTL, v);  chk("R12 enables kept", v, 32'h1C);
        rd(A_BASE, v); chk("R12 base cleared", v, 0);
        rd(A_IDX, v);  chk("R12 index cleared", v, 32'h0001_0000);
    endtask

    task automatic t_stall();
        put_desc(0, 32'h2C0, 32'h0000_0006);
        ngot = 0;
        wr(A_BASE, LIST);
        wr(A_IDX, 32'd0);
        stall = 1'b1;
        wr(A_CTL, 32'h1D);
        wait_lvb();
        stall = 1'b0;
        chk("R2 count under stalls", 32'(ngot), 32'd6);
        for (int i = 0; i < 6; i++) chk("R2 order under stalls", got[i], wexp('h2C0 + 4*i));
        chk("R8 irq on last-buffer done", 32'(irq), 1);
    endtask

    task automatic t_fill();
        logic [31:0] v;
        chan_reset();
        put_desc(0, 32'h300, 32'h4000_0002);
        put_desc(1, 32'h340, 32'h0000_0001);
        wr(A_IDX, 32'd0);
        wr(A_CTL, 32'h01);
        wait_lvb();
        @(negedge clk);
        chk("R9 zero fill offered", 32'(smp_valid), 1);
        chk("R9 zero fill data", smp_data, 0);
        repeat (5) @(negedge clk);
        chk("R9 fill samples delivered", 32'(ngot > 4), 1);
        chk("R9 data before fill", got[1], wexp('h304));
        chk("R9 fill sample value", got[2], 0);
        wr(A_STS, 32'h4);
        wr(A_IDX, 32'd1);
        wait_lvb();
        chk("R10 resumed buffer sample", got[ngot-1], wexp('h340));
        rd(A_IDX, v); chk("R10 index after resume", v, 32'h0002_0101);
        @(negedge clk);
        chk("R9 no fill without policy bit", 32'(smp_valid), 0);
    endtask

    task automatic t_pause();
        logic [31:0] p1, p2, v;
        int r0, g0;
        chan_reset();
        put_desc(0, 32'h380, 32'h0000_0008);
        wr(A_IDX, 32'd0);
        wr(A_CTL, 32'h01);
        wait (ngot == 3);
        wr(A_CTL, 32'h00);
        rd(A_STS, v); chk("R11 halted while paused", v & 32'h1, 32'h1);
        rd(A_POS, p1);
        r0 = nreq; g0 = ngot;
        repeat (10) @(negedge clk);
        rd(A_POS, p2);
        chk("R11 position frozen", p2, p1);
        chk("R11 no reads while paused", 32'(nreq), 32'(r0));
        chk("R11 no samples while paused", 32'(ngot), 32'(g0));
        wr(A_CTL, 32'h01);
        wait_lvb();
        chk("R11 total after resume", 32'(ngot), 32'd8);
        for (int i = 0; i < 8; i++) chk("R11 order across pause", got[i], wexp('h380 + 4*i));
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        chan_reset();
        for (int i = 0; i < 32; i++) put_desc(i, 32'h3C0, 32'h0);
        wr(A_IDX, 32'd31);
        wr(A_CTL, 32'h01);
        wait_lvb();
        rd(A_IDX, v); chk("R4 prefetch wraps to 0", v, 32'h0000_1F1F);
        chk("R2 empty buffers give no data", 32'(ngot), 0);
        put_desc(0, 32'h3C0, 32'h0000_0001);
        wr(A_STS, 32'h4);
        wr(A_IDX, 32'd0);
        wait_lvb();
        rd(A_IDX, v); chk("R4 current wraps to 0", v, 32'h0001_0000);
        chk("R4 sample after wrap", got[0], wexp('h3C0));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_play();
        t_regreset();
        t_stall();
        t_fill();
        t_pause();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule